// File: doc/BRIEF.md
# Phase-Locked Timing Generator with Gated Complementary Drives

This block derives every low-rate timing signal of a subsystem from one master clock. A single modulo counter divides the master clock down to a square wave (nominally 172.8 kHz from an 11.0592 MHz clock, a ratio of 64). Each rising edge of that square wave fires a short fixed-width sync pulse for an external switching regulator. The same edge clocks two toggle stages that produce two complementary drive pairs, one for an RF inverter and one for a high-voltage inverter, each at half the square-wave rate.

Each drive pair has its own enable bit. With the enable low, both outputs of the pair are parked high. When the enable returns, the pair stays parked until the next square-wave rising edge. It then restarts with its true output low, so it never produces a short half-period. A converter strobe, one master cycle wide, is taken from the same chain at a fixed count once every 256 square-wave periods (675 Hz nominal). All outputs are therefore phase-locked sub-multiples of one another.

A synchronous reset clears the chain and parks both pairs. The square wave, the sync pulse and the strobe stay quiet until one full square-wave period has elapsed. The parameters must satisfy these limits: `SQ_DIV` even and at least 4, `PULSE_CYC` between 1 and `SQ_DIV/2`, and `CONV_DIV` at least 2.

Top module: `tg_timing_gen`

## Requirements
- R1: While `rst` is sampled high, the next clock edge sets `rf_q_o`, `rf_qn_o`, `hv_q_o` and `hv_qn_o` to 1 and sets `sq_o`, `sync_o` and `conv_o` to 0.
- R2: Counting clock edges after reset release as n = 1, 2, …, `sq_o` is 0 for n < `SQ_DIV`. For n ≥ `SQ_DIV` it is 1 when (n mod `SQ_DIV`) < `SQ_DIV/2` and 0 otherwise, so its period is `SQ_DIV` cycles.
- R3: `sync_o` is 1 exactly when n ≥ `SQ_DIV` and (n mod `SQ_DIV`) < `PULSE_CYC`. That is one pulse of `PULSE_CYC` cycles, starting on the same cycle as each rising edge of `sq_o`.
- R4: While a pair's enable stays high after the pair has restarted, the pair inverts both outputs on every rising edge of `sq_o` and holds them at all other times. Its period is therefore 2·`SQ_DIV` cycles.
- R5: While a pair is enabled and running, its Q and Qn outputs are always in opposite states, and no pair ever has both outputs low.
- R6: An edge that samples `rf_en_i` low sets both `rf_q_o` and `rf_qn_o` to 1, and they remain 1 while the enable stays low.
- R7: An edge that samples `hv_en_i` low sets both `hv_q_o` and `hv_qn_o` to 1, independently of the RF pair.
- R8: After an enable rises, the pair stays parked (both outputs 1) until the next rising edge of `sq_o`. On that edge Q becomes 0 and Qn becomes 1.
- R9: `conv_o` is 1 for exactly one cycle when n > 0 and n is a multiple of `SQ_DIV`·`CONV_DIV`, and 0 otherwise. Every strobe coincides with the first cycle of a sync pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| rf_en_i | input | 1 | RF drive enable; low parks the RF pair high |
| hv_en_i | input | 1 | High-voltage drive enable; low parks the HV pair high |
| sq_o | output | 1 | Square wave at master/`SQ_DIV` |
| sync_o | output | 1 | Regulator sync pulse, `PULSE_CYC` cycles wide |
| rf_q_o | output | 1 | RF drive, true output |
| rf_qn_o | output | 1 | RF drive, complement output |
| hv_q_o | output | 1 | HV drive, true output |
| hv_qn_o | output | 1 | HV drive, complement output |
| conv_o | output | 1 | Converter strobe, one cycle per `SQ_DIV`·`CONV_DIV` cycles |

## Verification
The bench builds the block with `SQ_DIV`=8, `PULSE_CYC`=3 and `CONV_DIV`=4. A converter strobe then arrives every 32 cycles, so dozens of strobe periods and drive toggles fit into a short run. A three-cycle pulse exercises the pulse shaper's count-down path, which a one-cycle pulse would leave unused. The small period also makes it easy to place enable changes just before, on and just after a square-wave edge. Enable glitches shorter than a period are included as well, and so is a second reset issued in mid-run.

// File: rtl/tg_pkg.sv
package tg_pkg;
  // One complementary drive pair: true and complement outputs
  typedef struct packed {
    logic q;
    logic qn;
  } drv_pair_t;

  localparam drv_pair_t DRV_PARKED = '{q: 1'b1, qn: 1'b1};

  // Indices of the drive pairs inside the generated array
  localparam int DRV_RF  = 0;
  localparam int DRV_HV  = 1;
  localparam int NUM_DRV = 2;
endpackage

// File: rtl/tg_prescaler.sv
module tg_prescaler #(
  parameter int SQ_DIV = 64
) (
  input  logic clk,
  input  logic rst,
  output logic wrap_o,   // counter is at its last value this cycle
  output logic sq_o
);
  localparam int CW   = (SQ_DIV > 1) ? $clog2(SQ_DIV) : 1;
  localparam int HALF = SQ_DIV / 2;
  localparam logic [CW-1:0] LAST   = CW'(SQ_DIV - 1);
  localparam logic [CW-1:0] HALF_C = CW'(HALF);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;
  logic          primed_q;
  logic          primed_nxt;
  logic          sq_q;

  assign wrap_o     = (cnt_q == LAST);
  assign cnt_nxt    = wrap_o ? '0 : cnt_q + 1'b1;
  assign primed_nxt = primed_q | wrap_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      primed_q <= 1'b0;
      sq_q     <= 1'b0;
    end else begin
      cnt_q    <= cnt_nxt;
      primed_q <= primed_nxt;
      sq_q     <= primed_nxt && (cnt_nxt < HALF_C);
    end
  end

  assign sq_o = sq_q;
endmodule

// File: rtl/tg_pulse_shaper.sv
module tg_pulse_shaper #(
  parameter int PULSE_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int RW = $clog2(PULSE_CYC + 1);
  localparam logic [RW-1:0] LOAD = RW'(PULSE_CYC - 1);

  logic [RW-1:0] rem_q;
  logic          pulse_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q   <= '0;
      pulse_q <= 1'b0;
    end else if (trig_i) begin
      rem_q   <= LOAD;
      pulse_q <= 1'b1;
    end else if (rem_q != '0) begin
      rem_q   <= rem_q - 1'b1;
      pulse_q <= 1'b1;
    end else begin
      pulse_q <= 1'b0;
    end
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/tg_drive_pair.sv
module tg_drive_pair
  import tg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      en_i,
  input  logic      edge_i,   // square-wave rising edge event
  output drv_pair_t drv_o
);
  drv_pair_t drv_q;
  logic      run_q;

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      drv_q <= DRV_PARKED;
      run_q <= 1'b0;
    end else if (edge_i) begin
      if (!run_q) begin
        drv_q <= '{q: 1'b0, qn: 1'b1};
        run_q <= 1'b1;
      end else begin
        drv_q <= '{q: ~drv_q.q, qn: ~drv_q.qn};
      end
    end
  end

  assign drv_o = drv_q;
endmodule

// File: rtl/tg_conv_div.sv
module tg_conv_div #(
  parameter int CONV_DIV = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic edge_i,
  output logic strobe_o
);
  localparam int PW = (CONV_DIV > 1) ? $clog2(CONV_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(CONV_DIV - 1);

  logic [PW-1:0] per_q;
  logic          stb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      per_q <= '0;
      stb_q <= 1'b0;
    end else begin
      stb_q <= edge_i && (per_q == LAST);
      if (edge_i) per_q <= (per_q == LAST) ? '0 : per_q + 1'b1;
    end
  end

  assign strobe_o = stb_q;
endmodule

// File: rtl/tg_timing_gen.sv
module tg_timing_gen
  import tg_pkg::*;
#(
  parameter int SQ_DIV    = 64,
  parameter int PULSE_CYC = 2,
  parameter int CONV_DIV  = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic rf_en_i,
  input  logic hv_en_i,
  output logic sq_o,
  output logic sync_o,
  output logic rf_q_o,
  output logic rf_qn_o,
  output logic hv_q_o,
  output logic hv_qn_o,
  output logic conv_o
);
  logic                    wrap;
  logic [NUM_DRV-1:0]      en_vec;
  drv_pair_t [NUM_DRV-1:0] drv_vec;

  tg_prescaler #(.SQ_DIV(SQ_DIV)) u_pre (
    .clk(clk), .rst(rst), .wrap_o(wrap), .sq_o(sq_o)
  );

  tg_pulse_shaper #(.PULSE_CYC(PULSE_CYC)) u_sync (
    .clk(clk), .rst(rst), .trig_i(wrap), .pulse_o(sync_o)
  );

  tg_conv_div #(.CONV_DIV(CONV_DIV)) u_conv (
    .clk(clk), .rst(rst), .edge_i(wrap), .strobe_o(conv_o)
  );

  assign en_vec[DRV_RF] = rf_en_i;
  assign en_vec[DRV_HV] = hv_en_i;

  for (genvar g = 0; g < NUM_DRV; g++) begin : g_drv
    tg_drive_pair u_pair (
      .clk(clk), .rst(rst), .en_i(en_vec[g]), .edge_i(wrap), .drv_o(drv_vec[g])
    );
  end

  assign rf_q_o  = drv_vec[DRV_RF].q;
  assign rf_qn_o = drv_vec[DRV_RF].qn;
  assign hv_q_o  = drv_vec[DRV_HV].q;
  assign hv_qn_o = drv_vec[DRV_HV].qn;
endmodule

// File: rtl/tg_timing_chk.sv
module tg_timing_chk (
  input logic clk,
  input logic rst,
  input logic rf_en_i,
  input logic hv_en_i,
  input logic sq_o,
  input logic sync_o,
  input logic rf_q_o,
  input logic rf_qn_o,
  input logic hv_q_o,
  input logic hv_qn_o,
  input logic conv_o
);
  // R5
  rf_never_both_low_chk: assert property (@(posedge clk) disable iff (rst)
    !(!rf_q_o && !rf_qn_o));

  // R5
  hv_never_both_low_chk: assert property (@(posedge clk) disable iff (rst)
    !(!hv_q_o && !hv_qn_o));

  // R6
  rf_park_chk: assert property (@(posedge clk) disable iff (rst)
    !rf_en_i |=> (rf_q_o && rf_qn_o));

  // R7
  hv_park_chk: assert property (@(posedge clk) disable iff (rst)
    !hv_en_i |=> (hv_q_o && hv_qn_o));

  // R3
  sync_on_sq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_o) |-> $rose(sq_o));

  // R9
  conv_on_sync_chk: assert property (@(posedge clk) disable iff (rst)
    conv_o |-> $rose(sync_o));

  // R9
  conv_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    conv_o |=> !conv_o);

  // R4
  rf_moves_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(rf_q_o) |-> ($rose(sync_o) || !$past(rf_en_i)));
endmodule

bind tg_timing_gen tg_timing_chk u_chk (.*);

// File: tb/sim_tg_timing_gen.sv
module sim_tg_timing_gen;
  localparam int SQ_DIV    = 8;
  localparam int PULSE_CYC = 3;
  localparam int CONV_DIV  = 4;
  localparam int HALF      = SQ_DIV / 2;
  localparam int WATCHDOG  = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rf_en = 1'b0;
  logic hv_en = 1'b0;
  logic sq, sync, rf_q, rf_qn, hv_q, hv_qn, conv;

  int errors = 0;
  int checks = 0;
  int cyc    = 0;

  // behavioural reference state
  int n_m = 0;
  int phase_m = 0;
  bit sq_m = 0, sync_m = 0, conv_m = 0;
  bit rst_seen = 0;
  bit rfq_m = 1, rfqn_m = 1, rfrun_m = 0;
  bit hvq_m = 1, hvqn_m = 1, hvrun_m = 0;

  always #2 clk = ~clk;   // 250 MHz

  tg_timing_gen #(.SQ_DIV(SQ_DIV), .PULSE_CYC(PULSE_CYC), .CONV_DIV(CONV_DIV)) u0 (
    .clk(clk), .rst(rst), .rf_en_i(rf_en), .hv_en_i(hv_en),
    .sq_o(sq), .sync_o(sync), .rf_q_o(rf_q), .rf_qn_o(rf_qn),
    .hv_q_o(hv_q), .hv_qn_o(hv_qn), .conv_o(conv)
  );

  task automatic check(input string req, input string what, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual=%0b expected=%0b", req, what, cyc, act, exp);
    end
  endtask

  task automatic step_pair(input bit en, input bit edge_ev, inout bit q, inout bit qn, inout bit run);
    if (!en) begin
      q = 1; qn = 1; run = 0;
    end else if (edge_ev) begin
      if (!run) begin q = 0; qn = 1; run = 1; end
      else begin q = ~q; qn = ~qn; end
    end
  endtask

  // reference update on each active edge
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      rst_seen = 1;
      n_m = 0; phase_m = 0;
      sq_m = 0; sync_m = 0; conv_m = 0;
      rfq_m = 1; rfqn_m = 1; rfrun_m = 0;
      hvq_m = 1; hvqn_m = 1; hvrun_m = 0;
    end else begin
      bit edge_ev;
      n_m++;
      phase_m = n_m % SQ_DIV;
      edge_ev = (n_m >= SQ_DIV) && (phase_m == 0);
      sq_m   = (n_m >= SQ_DIV) && (phase_m < HALF);
      sync_m = (n_m >= SQ_DIV) && (phase_m < PULSE_CYC);
      conv_m = (n_m % (SQ_DIV * CONV_DIV)) == 0;
      step_pair(rf_en, edge_ev, rfq_m, rfqn_m, rfrun_m);
      step_pair(hv_en, edge_ev, hvq_m, hvqn_m, hvrun_m);
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (rst_seen) begin
      if (n_m == 0) begin
        // R1 reset state
        check("R1", "rf_q",  rf_q,  1'b1);
        check("R1", "rf_qn", rf_qn, 1'b1);
        check("R1", "hv_q",  hv_q,  1'b1);
        check("R1", "hv_qn", hv_qn, 1'b1);
        check("R1", "sq",    sq,    1'b0);
        check("R1", "sync",  sync,  1'b0);
        check("R1", "conv",  conv,  1'b0);
      end else begin
        check("R2", "sq",   sq,   sq_m);
        check("R3", "sync", sync, sync_m);
        check("R9", "conv", conv, conv_m);
        check(!rf_en ? "R6" : (rfrun_m ? "R4" : "R8"), "rf_q",  rf_q,  rfq_m);
        check(!rf_en ? "R6" : (rfrun_m ? "R4" : "R8"), "rf_qn", rf_qn, rfqn_m);
        check(!hv_en ? "R7" : (hvrun_m ? "R4" : "R8"), "hv_q",  hv_q,  hvq_m);
        check(!hv_en ? "R7" : (hvrun_m ? "R4" : "R8"), "hv_qn", hv_qn, hvqn_m);
        if (rfrun_m) check("R5", "rf complement", rf_q ^ rf_qn, 1'b1);
        if (hvrun_m) check("R5", "hv complement", hv_q ^ hv_qn, 1'b1);
      end
    end
  end

  task automatic wait_cyc(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  initial begin
    wait_cyc(4);
    rst = 0;
    rf_en = 1; hv_en = 1;
    wait_cyc(150);
    rf_en = 0;                // R6: disable mid-period
    wait_cyc(37);
    rf_en = 1;                // R8: re-enable mid-period
    wait_cyc(60);
    wait (n_m % SQ_DIV == SQ_DIV - 1);
    @(negedge clk);
    hv_en = 0;                // R7: disable right at an edge
    wait_cyc(21);
    hv_en = 1;
    wait_cyc(2);
    hv_en = 0;                // short glitch
    wait_cyc(1);
    hv_en = 1;
    wait_cyc(80);
    rf_en = 0; hv_en = 0;
    wait_cyc(3);
    rf_en = 1;
    wait_cyc(SQ_DIV * 3 + 1);
    hv_en = 1;
    wait_cyc(100);
    rst = 1;                  // R1: mid-run reset
    wait_cyc(3);
    rst = 0;
    wait_cyc(300);
    rf_en = 0;
    wait_cyc(SQ_DIV);
    rf_en = 1;
    wait_cyc(200);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait_cyc(WATCHDOG);
    errors++;
    checks++;
    $display("FAIL watchdog expired at cycle %0d: actual=running expected=done", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule